// File: doc/BRIEF.md
# Shift-Register Rate Timer

This block sets the pace of a sample-playback channel. It counts with a 9-bit maximal-length shift register instead of a binary down-counter. A 4-bit rate index picks a starting state from a table that is built when the design is elaborated. The register advances once every second enabled clock. When it reaches the fixed terminal state, which has only the top bit set, the block raises a single-cycle tick and starts the next period from a fresh starting state.

The rate table is a parameter that gives, for each rate index, the number of register steps in a period. Each step takes two enabled clocks. The matching starting states come from running the register backwards from the terminal state, so the table is written in steps rather than in shift-register codes. A new rate index is taken only when a period ends, so a period in progress always runs to completion. The clock-enable freezes the timer completely while it is low.

Top module: `lfsr_rate_timer`

## Requirements
- R1: While reset is held the tick is low. After reset is released with the enable held high, the first tick is visible in the cycle that follows enabled clock number 2·S, where S is the step count of the rate index that was present during reset.
- R2: With the default table, rate indices 0 to 15 give step counts S = 214, 190, 170, 160, 143, 127, 113, 107, 95, 80, 71, 64, 53, 42, 36, 27 in that order. Consecutive ticks are exactly 2·S enabled clocks apart.
- R3: The tick is high for exactly one clock and is never high in two consecutive cycles.
- R4: A change of the rate index during a period does not alter that period. The index present on the enabled clock edge that ends a period sets the length of the following period.
- R5: While the enable is low the timer does not advance and no tick is produced. Only enabled clocks count towards a period.
- R6: A synchronous reset in mid-period restarts timing. The next tick comes 2·S enabled clocks after release, where S belongs to the rate index present at reset.
- R7: The counting register is 9 bits wide. It shifts toward bit 0, and bit 8 receives bit 0 XOR bit 4. Its terminal state is 9'b100000000, and it is never all zeros. Any step count from 1 to 511 yields a period of 2·S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high; loads the start state for the current rate |
| en_i | input | 1 | Clock-enable; when low the timer holds its state |
| rate_i | input | 4 | Rate index into the step table |
| tick_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench builds two instances that share their inputs.

- **Default table:** the first instance uses the table of R2.
- **Extreme table:** the second instance uses step counts of 1, 2, 3, 4, 5, 8, 16, 31, 64, 100, 128, 255, 256, 300, 400 and 511. This puts the shortest possible period of two clocks within reach, along with a period that walks the whole 511-state cycle of the register. If the feedback taps were wrong, the backward-computed starting states would not return to the terminal state after the expected number of forward steps.

With both tables, the rate-change, enable-gap and mid-period-reset cases are checked against very short and very long periods at once.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

    localparam int unsigned DEF_NUM_RATES = 16;
    localparam int unsigned DEF_LFSR_W    = 9;
    localparam int unsigned DEF_TAP_HI    = 4;

    // Steps per period for each rate index (period = 2 * steps input clocks).
    localparam int unsigned DEF_STEPS [DEF_NUM_RATES] = '{
        214, 190, 170, 160, 143, 127, 113, 107,
        95,  80,  71,  64,  53,  42,  36,  27
    };

    // Half-rate phase: the register moves only on the second enabled clock.
    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_STEP = 1'b1
    } phase_e;

endpackage

// File: rtl/lfsr_div_phase.sv
module lfsr_div_phase
    import lfsr_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic step_o
);

    phase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (rst_i) begin
            phase_d = PH_WAIT;
        end else if (en_i) begin
            phase_d = (phase_q == PH_WAIT) ? PH_STEP : PH_WAIT;
        end
    end

    always_ff @(posedge clk_i) begin
        phase_q <= phase_d;
    end

    assign step_o = en_i && (phase_q == PH_STEP);

    AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(phase_q)); // R5

    AST_PHASE_ALTERNATES: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (phase_q != $past(phase_q))); // R2

endmodule

// File: rtl/lfsr_div_seed_rom.sv
module lfsr_div_seed_rom #(
    parameter int unsigned NUM_RATES = 16,
    parameter int unsigned RATE_W    = 4,
    parameter int unsigned LFSR_W    = 9,
    parameter int unsigned TAP_HI    = 4,
    parameter int unsigned STEPS [NUM_RATES] = lfsr_div_pkg::DEF_STEPS
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [LFSR_W-1:0] seed_o
);

    localparam logic [LFSR_W-1:0] TERM = {1'b1, {(LFSR_W-1){1'b0}}};

    // Inverse of one forward step (forward: shift toward bit 0,
    // bit 0 ^ bit TAP_HI enters at the top).
    function automatic logic [LFSR_W-1:0] back_step(input logic [LFSR_W-1:0] n);
        back_step = {n[LFSR_W-2:0], n[LFSR_W-1] ^ n[TAP_HI-1]};
    endfunction

    // State that reaches TERM after (steps - 1) forward steps; the final
    // step of a period is the reload taken while TERM is held.
    function automatic logic [LFSR_W-1:0] seed_for(input int unsigned steps);
        logic [LFSR_W-1:0] s;
        s = TERM;
        for (int unsigned i = 1; i < steps; i++) begin
            s = back_step(s);
        end
        return s;
    endfunction

    logic [LFSR_W-1:0] seeds_w [NUM_RATES];

    for (genvar k = 0; k < NUM_RATES; k++) begin : g_seed
        localparam logic [LFSR_W-1:0] SEED_K = seed_for(STEPS[k]);
        assign seeds_w[k] = SEED_K;
    end

    always_comb begin
        seed_o = seeds_w[0];
        for (int k = 0; k < NUM_RATES; k++) begin
            if (rate_i == RATE_W'(k)) begin
                seed_o = seeds_w[k];
            end
        end
    end

endmodule

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
    parameter int unsigned LFSR_W = 9,
    parameter int unsigned TAP_HI = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic              tick_o
);

    localparam logic [LFSR_W-1:0] TERM = {1'b1, {(LFSR_W-1){1'b0}}};

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              tick;
    } core_t;

    core_t core_d, core_q;
    logic  at_term;
    logic  feedback;

    assign at_term  = (core_q.lfsr == TERM);
    assign feedback = core_q.lfsr[0] ^ core_q.lfsr[TAP_HI];

    always_comb begin
        core_d      = core_q;
        core_d.tick = 1'b0;
        if (rst_i) begin
            core_d.lfsr = seed_i;
        end else if (step_i) begin
            if (at_term) begin
                core_d.lfsr = seed_i;
                core_d.tick = 1'b1;
            end else begin
                core_d.lfsr = {feedback, core_q.lfsr[LFSR_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        core_q <= core_d;
    end

    assign tick_o = core_q.tick;

    AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        core_q.lfsr != '0); // R7

    AST_SHIFT_TOWARD_LSB: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !at_term) |=> (core_q.lfsr[LFSR_W-2:0] == $past(core_q.lfsr[LFSR_W-1:1]))); // R7

    AST_TICK_FROM_TERMINAL: assert property (@(posedge clk_i) disable iff (rst_i)
        core_q.tick |-> $past(step_i && at_term)); // R1

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        core_q.tick |=> !core_q.tick); // R3

endmodule

// File: rtl/lfsr_rate_timer.sv
module lfsr_rate_timer #(
    parameter int unsigned NUM_RATES = lfsr_div_pkg::DEF_NUM_RATES,
    parameter int unsigned RATE_W    = $clog2(NUM_RATES),
    parameter int unsigned LFSR_W    = lfsr_div_pkg::DEF_LFSR_W,
    parameter int unsigned TAP_HI    = lfsr_div_pkg::DEF_TAP_HI,
    parameter int unsigned STEPS [NUM_RATES] = lfsr_div_pkg::DEF_STEPS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);

    logic              step_w;
    logic [LFSR_W-1:0] seed_w;

    lfsr_div_phase i_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .step_o (step_w)
    );

    lfsr_div_seed_rom #(
        .NUM_RATES (NUM_RATES),
        .RATE_W    (RATE_W),
        .LFSR_W    (LFSR_W),
        .TAP_HI    (TAP_HI),
        .STEPS     (STEPS)
    ) i_seed_rom (
        .rate_i (rate_i),
        .seed_o (seed_w)
    );

    lfsr_div_core #(
        .LFSR_W (LFSR_W),
        .TAP_HI (TAP_HI)
    ) i_core (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (step_w),
        .seed_i (seed_w),
        .tick_o (tick_o)
    );

    AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !tick_o); // R5

endmodule

// File: tb/test_lfsr_rate_timer.sv
`timescale 1ns/1ps
module test_lfsr_rate_timer;

    localparam int unsigned STEPS_A [16] = '{
        214, 190, 170, 160, 143, 127, 113, 107,
        95,  80,  71,  64,  53,  42,  36,  27
    };
    localparam int unsigned STEPS_B [16] = '{
        1, 2, 3, 4, 5, 8, 16, 31,
        64, 100, 128, 255, 256, 300, 400, 511
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [3:0] rate = 4'd0;
    logic       tick_a, tick_b;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    int  cnt   [2];
    int  cur   [2];
    int  per   [2];
    int  since [2];
    bit  expt  [2];
    bit  prevt [2];

    always #4 clk = ~clk;

    lfsr_rate_timer #(.STEPS(STEPS_A)) i_lfsr_rate_timer (
        .clk_i (clk), .rst_i (rst), .en_i (en), .rate_i (rate), .tick_o (tick_a)
    );

    lfsr_rate_timer #(.STEPS(STEPS_B)) i_lfsr_rate_timer_edge (
        .clk_i (clk), .rst_i (rst), .en_i (en), .rate_i (rate), .tick_o (tick_b)
    );

    function automatic int steps_of(int d, int r);
        return (d == 0) ? int'(STEPS_A[r]) : int'(STEPS_B[r]);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: update the behavioural model at the edge, compare after it.
    task automatic clk_step(string req);
        bit obs [2];
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                cnt[d] = 0; cur[d] = int'(rate); since[d] = 0; expt[d] = 1'b0;
            end else if (en) begin
                cnt[d]++; since[d]++;
                if (cnt[d] == 2 * steps_of(d, cur[d])) begin
                    expt[d] = 1'b1;
                    per[d]  = 2 * steps_of(d, cur[d]);
                    cnt[d]  = 0;
                    cur[d]  = int'(rate);
                end else begin
                    expt[d] = 1'b0;
                end
            end else begin
                expt[d] = 1'b0;
            end
        end
        #1;
        obs[0] = tick_a;
        obs[1] = tick_b;
        for (int d = 0; d < 2; d++) begin
            check(req, $sformatf("tick inst%0d", d), int'(obs[d]), int'(expt[d]));
            if (obs[d]) begin
                check("R2", $sformatf("enabled clocks between ticks inst%0d", d), since[d], per[d]);
                since[d] = 0;
                check("R3", $sformatf("tick width inst%0d", d), int'(prevt[d]), 0);
            end
            prevt[d] = obs[d];
        end
    endtask

    task automatic run(int n, string req);
        for (int i = 0; i < n; i++) clk_step(req);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            cnt[d] = 0; cur[d] = 0; per[d] = 0; since[d] = 0; expt[d] = 0; prevt[d] = 0;
        end
        rst = 1'b1; en = 1'b1; rate = 4'd0;
        run(3, "R1");
        check("R1", "tick held in reset inst0", int'(tick_a), 0);
        check("R1", "tick held in reset inst1", int'(tick_b), 0);
        rst = 1'b0;
        // R1 first period, then R2 / R7 for every rate on both tables
        run(600, "R1");
        for (int r = 0; r < 16; r++) begin
            rate = 4'(r);
            run(2100, "R2");
        end
        // R7: walk the full 511-state cycle from a clean reset
        rate = 4'd15; rst = 1'b1;
        run(2, "R7");
        rst = 1'b0;
        run(2100, "R7");
        // R4: rate changes inside periods
        rate = 4'd0;
        run(100, "R4");
        rate = 4'd12;
        run(50, "R4");
        rate = 4'd3;
        run(700, "R4");
        rate = 4'd9;
        run(300, "R4");
        // R5: long idle stretch, then a gappy enable
        en = 1'b0;
        run(600, "R5");
        for (int i = 0; i < 3000; i++) begin
            en = (i % 3) != 2;
            clk_step("R5");
        end
        en = 1'b1;
        // R6: reset in mid-period with a new rate
        rate = 4'd5;
        run(150, "R6");
        rate = 4'd2; rst = 1'b1;
        run(1, "R6");
        rst = 1'b0;
        run(1200, "R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule